// File: doc/BRIEF.md
# Next-PC Sequencer with Branch Delay Slot

This block produces the fetch address of a 32-bit RISC core that has a single branch delay slot. Each time `step_i` is high at a rising clock edge, the instruction at the current fetch address retires. Its control-transfer class, offset, register operand and the status flag decide the next address. A taken branch or any jump does not redirect fetch at once. The instruction that follows it always executes first, and fetch then moves to the target captured at the transfer. Return-from-exception is the only transfer that acts at once. It loads the saved exception address and asks for the saved status word to be written back into the status register.

The sequencer also produces the link-register write for the two linking jumps. Both write strobes are registered and stay high for exactly one cycle after the step that caused them. Only one target can be pending at a time. Any transfer decoded while a delay slot executes is dropped.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, `fetch_pc_o` is 0x100, and `link_we_o` and `sr_we_o` are 0. No transfer is pending when reset ends.
- R2: In a cycle where `step_i` is 0, `fetch_pc_o`, the pending target and the pending state do not change. Both write strobes are 0 in the cycle that follows.
- R3: `kind_i` encodes the class: 0 plain, 1 branch-if-flag, 2 branch-if-flag-clear, 3 relative jump, 4 relative jump with link, 5 register jump, 6 register jump with link, 7 return-from-exception. A plain instruction that is not in a delay slot moves fetch to PC+4.
- R4: Class 1 is taken only when `flag_i` is 1, and class 2 only when `flag_i` is 0. A branch that is not taken moves fetch to PC+4 and leaves nothing pending.
- R5: The target of classes 1 to 4 is the PC of the transfer plus `offset_i` sign-extended from 26 bits and multiplied by 4. The sum wraps modulo 2^32.
- R6: After a taken branch or any jump, the next fetch address is PC+4 (the delay slot). The step after that moves fetch to the captured target.
- R7: The target of classes 5 and 6 is the value of `target_i` at the transfer step, whatever `target_i` does later.
- R8: Classes 4 and 6 raise `link_we_o` for the single cycle after their step. In that cycle `link_val_o` is the transfer's PC+8 and `link_addr_o` is 9.
- R9: Class 7, outside a delay slot, moves fetch straight to `epc_i`. For the single cycle after the step it raises `sr_we_o`, with `sr_val_o` equal to `esr_i` at the step.
- R10: A step taken inside a delay slot ignores `kind_i` and `flag_i` entirely. It writes no link register and no status register, and fetch goes to the pending target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Retire the instruction at `fetch_pc_o` this cycle |
| kind_i | input | 3 | Control-transfer class of the retiring instruction |
| offset_i | input | 26 | Signed word offset for relative transfers |
| target_i | input | 32 | Register operand for register jumps |
| flag_i | input | 1 | Status flag tested by the conditional branches |
| epc_i | input | 32 | Saved exception PC |
| esr_i | input | 32 | Saved status word |
| fetch_pc_o | output | 32 | Address of the instruction to fetch |
| link_we_o | output | 1 | Link-register write strobe |
| link_addr_o | output | 5 | Register index of the link write |
| link_val_o | output | 32 | Return address written to the link register |
| sr_we_o | output | 1 | Status-register restore strobe |
| sr_val_o | output | 32 | Status word to restore |

## Verification
The bench aims at the cycle boundary of the delay slot. A design that redirects too early skips the slot instruction. One that redirects too late runs a second sequential instruction. It also puts jumps, linking jumps and exception returns inside a slot: a design that honours them writes a spurious link or status value, or strays from the first target. Negative offsets, a register operand that changes after the jump step, and pauses in `step_i` while a target is pending expose sign-extension errors, late sampling of the target and a pending state that leaks away while stalled.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int unsigned KIND_W = 3;

    // Control-transfer classes of the retiring instruction
    typedef enum logic [KIND_W-1:0] {
        XK_PLAIN         = 3'd0,
        XK_BR_SET        = 3'd1,
        XK_BR_CLR        = 3'd2,
        XK_JUMP          = 3'd3,
        XK_JUMP_LINK     = 3'd4,
        XK_JUMP_REG      = 3'd5,
        XK_JUMP_REG_LINK = 3'd6,
        XK_EXC_RETURN    = 3'd7
    } xfer_kind_e;

endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
    import pcseq_pkg::*;
(
    input  logic [KIND_W-1:0] kind_i,
    input  logic              flag_i,
    input  logic              in_slot_i,
    output logic              defer_o,
    output logic              use_reg_o,
    output logic              link_o,
    output logic              exc_ret_o
);

    xfer_kind_e kind;
    assign kind = xfer_kind_e'(kind_i);

    always_comb begin
        defer_o   = 1'b0;
        use_reg_o = 1'b0;
        link_o    = 1'b0;
        exc_ret_o = 1'b0;
        // a delay-slot instruction may not start another transfer
        if (!in_slot_i) begin
            unique case (kind)
                XK_BR_SET:        defer_o = flag_i;
                XK_BR_CLR:        defer_o = !flag_i;
                XK_JUMP:          defer_o = 1'b1;
                XK_JUMP_LINK: begin
                    defer_o = 1'b1;
                    link_o  = 1'b1;
                end
                XK_JUMP_REG: begin
                    defer_o   = 1'b1;
                    use_reg_o = 1'b1;
                end
                XK_JUMP_REG_LINK: begin
                    defer_o   = 1'b1;
                    use_reg_o = 1'b1;
                    link_o    = 1'b1;
                end
                XK_EXC_RETURN:    exc_ret_o = 1'b1;
                default:          ;
            endcase
        end
    end

endmodule

// File: rtl/pcseq_target.sv
module pcseq_target #(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned OFF_W      = 26,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic [XLEN-1:0]  reg_tgt_i,
    input  logic             use_reg_i,
    output logic [XLEN-1:0]  seq_pc_o,
    output logic [XLEN-1:0]  link_val_o,
    output logic [XLEN-1:0]  xfer_tgt_o
);

    localparam int unsigned SHIFT = $clog2(INSN_BYTES);
    localparam int unsigned EXT_W = XLEN - OFF_W - SHIFT;

    logic [XLEN-1:0] byte_off;

    // word offset, sign-extended and scaled to bytes
    assign byte_off   = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, {SHIFT{1'b0}}};
    assign seq_pc_o   = pc_i + XLEN'(INSN_BYTES);
    assign link_val_o = pc_i + XLEN'(2 * INSN_BYTES);
    assign xfer_tgt_o = use_reg_i ? reg_tgt_i : pc_i + byte_off;

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int unsigned      XLEN       = 32,
    parameter int unsigned      OFF_W      = 26,
    parameter int unsigned      INSN_BYTES = 4,
    parameter int unsigned      RADDR_W    = 5,
    parameter int unsigned      LINK_REG   = 9,
    parameter logic [XLEN-1:0]  RESET_PC   = 32'h0000_0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    input  logic [KIND_W-1:0]  kind_i,
    input  logic [OFF_W-1:0]   offset_i,
    input  logic [XLEN-1:0]    target_i,
    input  logic               flag_i,
    input  logic [XLEN-1:0]    epc_i,
    input  logic [XLEN-1:0]    esr_i,
    output logic [XLEN-1:0]    fetch_pc_o,
    output logic               link_we_o,
    output logic [RADDR_W-1:0] link_addr_o,
    output logic [XLEN-1:0]    link_val_o,
    output logic               sr_we_o,
    output logic [XLEN-1:0]    sr_val_o
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic            slot;
        logic [XLEN-1:0] tgt;
        logic            link_we;
        logic [XLEN-1:0] link_val;
        logic            sr_we;
        logic [XLEN-1:0] sr_val;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic            defer, use_reg, do_link, exc_ret;
    logic [XLEN-1:0] seq_pc, ret_addr, xfer_tgt;

    pcseq_decode u_decode (
        .kind_i    (kind_i),
        .flag_i    (flag_i),
        .in_slot_i (st_q.slot),
        .defer_o   (defer),
        .use_reg_o (use_reg),
        .link_o    (do_link),
        .exc_ret_o (exc_ret)
    );

    pcseq_target #(
        .XLEN       (XLEN),
        .OFF_W      (OFF_W),
        .INSN_BYTES (INSN_BYTES)
    ) u_target (
        .pc_i       (st_q.pc),
        .offset_i   (offset_i),
        .reg_tgt_i  (target_i),
        .use_reg_i  (use_reg),
        .seq_pc_o   (seq_pc),
        .link_val_o (ret_addr),
        .xfer_tgt_o (xfer_tgt)
    );

    always_comb begin
        st_d         = st_q;
        st_d.link_we = 1'b0;
        st_d.sr_we   = 1'b0;
        if (step_i) begin
            if (st_q.slot) begin
                // delay slot retires: redirect to the captured target
                st_d.pc   = st_q.tgt;
                st_d.slot = 1'b0;
            end else if (exc_ret) begin
                st_d.pc     = epc_i;
                st_d.sr_we  = 1'b1;
                st_d.sr_val = esr_i;
            end else begin
                st_d.pc = seq_pc;
                if (defer) begin
                    st_d.slot = 1'b1;
                    st_d.tgt  = xfer_tgt;
                end
                if (do_link) begin
                    st_d.link_we  = 1'b1;
                    st_d.link_val = ret_addr;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.pc       <= RESET_PC;
        end else begin
            st_q          <= st_d;
        end
    end

    assign fetch_pc_o  = st_q.pc;
    assign link_we_o   = st_q.link_we;
    assign link_addr_o = RADDR_W'(LINK_REG);
    assign link_val_o  = st_q.link_val;
    assign sr_we_o     = st_q.sr_we;
    assign sr_val_o    = st_q.sr_val;

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk
    import pcseq_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_i,
    input logic [KIND_W-1:0] kind_i,
    input logic [XLEN-1:0]   epc_i,
    input logic [XLEN-1:0]   esr_i,
    input logic [XLEN-1:0]   fetch_pc_o,
    input logic              link_we_o,
    input logic [XLEN-1:0]   link_val_o,
    input logic              sr_we_o,
    input logic [XLEN-1:0]   sr_val_o,
    input logic              slot_q,
    input logic [XLEN-1:0]   tgt_q
);

    AST_RESET_NO_STROBE: assert property (@(posedge clk)
        !rst_n |=> !link_we_o && !sr_we_o);                                   // R1

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(fetch_pc_o) && $stable(slot_q) && !link_we_o && !sr_we_o); // R2

    AST_SEQ_OR_SLOT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !slot_q && kind_i != XK_EXC_RETURN
        |=> fetch_pc_o == $past(fetch_pc_o) + 32'd4);                         // R6

    AST_SLOT_TO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && slot_q |=> fetch_pc_o == $past(tgt_q) && !slot_q);          // R10

    AST_SLOT_NO_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && slot_q |=> !link_we_o && !sr_we_o);                         // R10

    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !slot_q && (kind_i == XK_JUMP_LINK || kind_i == XK_JUMP_REG_LINK)
        |=> link_we_o && link_val_o == $past(fetch_pc_o) + 32'd8);            // R8

    AST_EXC_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !slot_q && kind_i == XK_EXC_RETURN
        |=> fetch_pc_o == $past(epc_i) && sr_we_o && sr_val_o == $past(esr_i)); // R9

endmodule

bind pc_sequencer pc_sequencer_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step_i),
    .kind_i     (kind_i),
    .epc_i      (epc_i),
    .esr_i      (esr_i),
    .fetch_pc_o (fetch_pc_o),
    .link_we_o  (link_we_o),
    .link_val_o (link_val_o),
    .sr_we_o    (sr_we_o),
    .sr_val_o   (sr_val_o),
    .slot_q     (st_q.slot),
    .tgt_q      (st_q.tgt)
);

// File: tb/test_pc_sequencer.sv
`timescale 1ns/1ps
module test_pc_sequencer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        step_i;
    logic [2:0]  kind_i;
    logic [25:0] offset_i;
    logic [31:0] target_i;
    logic        flag_i;
    logic [31:0] epc_i;
    logic [31:0] esr_i;
    logic [31:0] fetch_pc_o;
    logic        link_we_o;
    logic [4:0]  link_addr_o;
    logic [31:0] link_val_o;
    logic        sr_we_o;
    logic [31:0] sr_val_o;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    bit          finished = 1'b0;

    // bench reference state
    logic [31:0] m_pc;
    logic        m_slot;
    logic [31:0] m_tgt;
    string       m_tgt_tag;

    always #4 clk = ~clk;

    pc_sequencer i_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .kind_i(kind_i),
        .offset_i(offset_i), .target_i(target_i), .flag_i(flag_i),
        .epc_i(epc_i), .esr_i(esr_i), .fetch_pc_o(fetch_pc_o),
        .link_we_o(link_we_o), .link_addr_o(link_addr_o), .link_val_o(link_val_o),
        .sr_we_o(sr_we_o), .sr_val_o(sr_val_o)
    );

    function automatic logic [31:0] rel_tgt(input logic [31:0] pc, input logic [25:0] off);
        return pc + {{4{off[25]}}, off, 2'b00};
    endfunction

    function automatic bit is_taken(input logic [2:0] k, input logic fl);
        return (k == 3'd1 && fl) || (k == 3'd2 && !fl) || (k >= 3'd3 && k <= 3'd6);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        step_i = 1'b0;
        kind_i = 3'($urandom_range(0, 7));
        flag_i = 1'($urandom);
        target_i = $urandom;
        @(negedge clk);
        chk("R2", "pc hold", fetch_pc_o, m_pc);
        chk("R2", "link_we", 32'(link_we_o), 32'd0);
        chk("R2", "sr_we", 32'(sr_we_o), 32'd0);
    endtask

    task automatic do_step(input logic [2:0] k, input logic [25:0] off, input logic [31:0] rt,
                           input logic fl, input logic [31:0] ep, input logic [31:0] es);
        logic [31:0] e_pc, e_lval, e_sval;
        logic        e_lwe, e_swe;
        string       tag;
        e_lwe = 1'b0; e_swe = 1'b0; e_lval = 32'd0; e_sval = 32'd0;
        if (m_slot) begin
            e_pc   = m_tgt;
            m_slot = 1'b0;
            tag    = (k != 3'd0) ? "R10" : m_tgt_tag;
        end else if (k == 3'd7) begin
            e_pc  = ep; e_swe = 1'b1; e_sval = es;
            tag   = "R9";
        end else begin
            e_pc = m_pc + 32'd4;
            if (is_taken(k, fl)) begin
                m_slot    = 1'b1;
                m_tgt     = (k == 3'd5 || k == 3'd6) ? rt : rel_tgt(m_pc, off);
                m_tgt_tag = (k == 3'd5 || k == 3'd6) ? "R7" : "R5";
                tag       = "R6";
            end else begin
                tag = (k == 3'd1 || k == 3'd2) ? "R4" : "R3";
            end
            if (k == 3'd4 || k == 3'd6) begin
                e_lwe = 1'b1; e_lval = m_pc + 32'd8;
            end
        end
        kind_i = k; offset_i = off; target_i = rt; flag_i = fl; epc_i = ep; esr_i = es;
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        target_i = ~rt;               // later changes must not matter (R7)
        m_pc = e_pc;
        chk(tag, "fetch pc", fetch_pc_o, e_pc);
        chk(e_lwe ? "R8" : tag, "link_we", 32'(link_we_o), 32'(e_lwe));
        if (e_lwe) begin
            chk("R8", "link_val", link_val_o, e_lval);
            chk("R8", "link_addr", 32'(link_addr_o), 32'd9);
        end
        chk(e_swe ? "R9" : tag, "sr_we", 32'(sr_we_o), 32'(e_swe));
        if (e_swe) chk("R9", "sr_val", sr_val_o, e_sval);
    endtask

    initial begin
        #(8ns * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h0C0FFEE1);
        rst_n = 1'b0; step_i = 1'b0; kind_i = '0; offset_i = '0; target_i = '0;
        flag_i = 1'b0; epc_i = '0; esr_i = '0;
        m_pc = 32'h100; m_slot = 1'b0; m_tgt = '0; m_tgt_tag = "R5";
        repeat (3) @(negedge clk);
        chk("R1", "reset pc", fetch_pc_o, 32'h100);
        chk("R1", "reset link_we", 32'(link_we_o), 32'd0);
        chk("R1", "reset sr_we", 32'(sr_we_o), 32'd0);
        rst_n = 1'b1;

        // directed corner cases
        idle(); idle();                                              // R2
        do_step(3'd0, 26'h3, 32'h0, 1'b1, 32'h0, 32'h0);             // R3 -> 0x104
        do_step(3'd1, 26'h4, 32'h0, 1'b0, 32'h0, 32'h0);             // R4 not taken
        do_step(3'd2, 26'h4, 32'h0, 1'b1, 32'h0, 32'h0);             // R4 not taken
        do_step(3'd1, 26'h4, 32'h0, 1'b1, 32'h0, 32'h0);             // R4 taken, R6 slot
        idle();                                                      // R2 with pending target
        do_step(3'd0, 26'h0, 32'h0, 1'b0, 32'h0, 32'h0);             // R5 arrive
        do_step(3'd2, 26'h3FFFFFE, 32'h0, 1'b0, 32'h0, 32'h0);       // R5 negative offset
        do_step(3'd4, 26'h0, 32'h0, 1'b0, 32'h0, 32'h0);             // R10 linking jump in slot
        do_step(3'd4, 26'h40, 32'h0, 1'b0, 32'h0, 32'h0);            // R8 link
        do_step(3'd7, 26'h0, 32'h0, 1'b0, 32'h5000, 32'hFF);         // R10 return in slot
        do_step(3'd6, 26'h0, 32'h2000, 1'b0, 32'h0, 32'h0);          // R7, R8
        do_step(3'd3, 26'h1, 32'h0, 1'b1, 32'h0, 32'h0);             // R10 jump in slot
        do_step(3'd7, 26'h0, 32'h0, 1'b0, 32'h3000, 32'hA5);         // R9 immediate
        do_step(3'd5, 26'h0, 32'h0000_4444, 1'b0, 32'h0, 32'h0);     // R7
        do_step(3'd1, 26'h0, 32'h0, 1'b1, 32'h0, 32'h0);             // R10 branch in slot

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 4) == 0) idle();
            do_step(3'($urandom_range(0, 7)), 26'($urandom), $urandom, 1'($urandom),
                    $urandom & 32'hFFFF_FFFC, $urandom);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule